// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block sequences the power modes of a small microcontroller core. It holds one of seven modes: a Sleep mode with every clock stopped, three Run modes in which both the CPU and the peripherals are clocked, and three Idle modes in which only the peripherals run. Each Run or Idle mode draws its clock from the primary oscillator, the low-frequency secondary oscillator or the internal oscillator block.

Software chooses the target with an idle-enable bit and a two-bit source field, then issues a sleep strobe. While the core runs with the idle bit clear, a new source field value switches directly between the three Run modes. An interrupt wake request or a watchdog timeout returns the core to primary run from any mode, and so does reset.

The outputs are modelled as enables and a source select only. The source select uses break-before-make sequencing, so a downstream clock multiplexer never sees two sources selected at once.

Top module: `pm_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters primary run. `mode_code` is 1, both clock enables are 1 and `src_select` is 3'b001.
- R2: `mode_code` is always one of 0 Sleep, 1 primary run, 2 secondary run, 3 internal run, 4 primary idle, 5 secondary idle, 6 internal idle. The value 7 never appears.
- R3: The source field decodes 2'b00 as primary, 2'b01 as secondary, and 2'b10 or 2'b11 as internal. In `src_select`, bit 0 is primary, bit 1 is secondary and bit 2 is internal.
- R4: In a Run mode with `idle_sel` = 0 and no strobe or wake, the next edge moves the controller to the Run mode of the source field. With `idle_sel` = 1 and no strobe, the Run mode does not change.
- R5: A sleep strobe in a Run mode with `idle_sel` = 0 enters Sleep (mode 0) at the next edge. In Sleep both enables are 0.
- R6: A sleep strobe in a Run mode with `idle_sel` = 1 enters the Idle mode of the source that the current Run mode uses, whatever the source field holds. In Idle, `cpu_clk_en` is 0 and `periph_clk_en` is 1.
- R7: `irq_wake` or `wdt_wake` moves the controller from any mode to primary run at the next edge. A wake takes priority over a sleep strobe in the same cycle.
- R8: In Sleep and in the Idle modes, sleep strobes and changes of the source field or idle bit have no effect. The mode holds until a wake event.
- R9: `src_select` is never more than one-hot. It follows the mode's source one edge after the mode changes. When the source changes from one oscillator to another, `src_select` is 3'b000 for exactly one cycle between them. In Sleep it is 3'b000.
- R10: `cpu_clk_en` is 1 exactly in modes 1 to 3. `periph_clk_en` is 1 in every mode except 0. Both change in the same cycle as `mode_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_sel | input | 1 | 1: a strobe from Run enters Idle; 0: it enters Sleep |
| clk_src_sel | input | 2 | Source field: 00 primary, 01 secondary, 1x internal |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| irq_wake | input | 1 | Interrupt wake request |
| wdt_wake | input | 1 | Watchdog timeout wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| src_select | output | 3 | One-hot oscillator select (bit0 pri, bit1 sec, bit2 int) |
| mode_code | output | 3 | Current mode code |

## Verification
The mode sequencer is driven through a chain of one-cycle vectors. The chain covers Run-to-Run switching under each field value, with both internal encodings 10 and 11. It covers strobes with the idle bit at 0 and at 1, including a strobe whose field disagrees with the running source, which separates "current source" from "field source" for Idle entry. It also applies field changes and strobes during Sleep and Idle, which separates holding from following, and issues wakes alone and together with strobes, which checks wake priority. Directed sequences then follow the source select cycle by cycle through a source switch, Sleep entry, wake and same-source Idle entry, and they also check reset from an Idle mode.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int NUM_SRC = 3;
    localparam int MODE_W  = 3;
    localparam int FIELD_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_SLEEP    = 3'd0,
        PM_RUN_PRI  = 3'd1,
        PM_RUN_SEC  = 3'd2,
        PM_RUN_INT  = 3'd3,
        PM_IDLE_PRI = 3'd4,
        PM_IDLE_SEC = 3'd5,
        PM_IDLE_INT = 3'd6
    } pm_mode_e;

    typedef enum logic [1:0] {
        SRC_PRI  = 2'd0,
        SRC_SEC  = 2'd1,
        SRC_INT  = 2'd2,
        SRC_NONE = 2'd3
    } pm_src_e;

    typedef struct packed {
        logic    cpu_en;
        logic    per_en;
        pm_src_e src;
    } pm_clk_cfg_t;

    function automatic pm_src_e src_from_field(input logic [FIELD_W-1:0] f);
        case (f)
            2'b00:   return SRC_PRI;
            2'b01:   return SRC_SEC;
            default: return SRC_INT;
        endcase
    endfunction

    function automatic logic is_run(input pm_mode_e m);
        return (m == PM_RUN_PRI) || (m == PM_RUN_SEC) || (m == PM_RUN_INT);
    endfunction

    function automatic pm_src_e mode_src(input pm_mode_e m);
        case (m)
            PM_RUN_PRI, PM_IDLE_PRI: return SRC_PRI;
            PM_RUN_SEC, PM_IDLE_SEC: return SRC_SEC;
            PM_RUN_INT, PM_IDLE_INT: return SRC_INT;
            default:                 return SRC_NONE;
        endcase
    endfunction

    function automatic pm_mode_e run_of(input pm_src_e s);
        case (s)
            SRC_SEC: return PM_RUN_SEC;
            SRC_INT: return PM_RUN_INT;
            default: return PM_RUN_PRI;
        endcase
    endfunction

    function automatic pm_mode_e idle_of(input pm_src_e s);
        case (s)
            SRC_SEC: return PM_IDLE_SEC;
            SRC_INT: return PM_IDLE_INT;
            default: return PM_IDLE_PRI;
        endcase
    endfunction

    function automatic pm_clk_cfg_t mode_cfg(input pm_mode_e m);
        pm_clk_cfg_t c;
        c.cpu_en = is_run(m);
        c.per_en = (m != PM_SLEEP);
        c.src    = mode_src(m);
        return c;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input pm_src_e s);
        logic [NUM_SRC-1:0] oh;
        for (int i = 0; i < NUM_SRC; i++) begin
            oh[i] = (int'(s) == i);
        end
        return oh;
    endfunction

endpackage

// File: rtl/pm_next_mode.sv
module pm_next_mode
    import pm_pkg::*;
(
    input  pm_mode_e           mode_q,
    input  logic               idle_sel,
    input  logic [FIELD_W-1:0] src_field,
    input  logic               sleep_strobe,
    input  logic               wake,
    output pm_mode_e           mode_d
);

    pm_src_e field_src;
    pm_src_e cur_src;

    always_comb begin
        field_src = src_from_field(src_field);
        cur_src   = mode_src(mode_q);
        mode_d    = mode_q;
        if (wake) begin
            mode_d = PM_RUN_PRI;
        end else if (is_run(mode_q)) begin
            if (sleep_strobe) begin
                mode_d = idle_sel ? idle_of(cur_src) : PM_SLEEP;
            end else if (!idle_sel) begin
                mode_d = run_of(field_src);
            end
        end
    end

endmodule

// File: rtl/pm_mode_reg.sv
module pm_mode_reg
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pm_mode_e mode_d,
    output pm_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_RUN_PRI;
        else     mode_q <= mode_d;
    end

    p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
        mode_q != pm_mode_e'(3'd7));

endmodule

// File: rtl/pm_src_sel.sv
module pm_src_sel #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] want_oh,
    output logic [NUM_SRC-1:0] sel_q
);

    localparam logic [NUM_SRC-1:0] RESET_SEL = NUM_SRC'(1);

    logic switching;

    always_comb begin
        switching = (sel_q != '0) && (sel_q != want_oh);
    end

    always_ff @(posedge clk) begin
        if (rst)            sel_q <= RESET_SEL;
        else if (switching) sel_q <= '0;
        else                sel_q <= want_oh;
    end

    p_sel_onehot0_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_q));

    p_break_before_make_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_q != '0) |=> (sel_q == '0) || $stable(sel_q));

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
    import pm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         idle_sel,
    input  logic [1:0]   clk_src_sel,
    input  logic         sleep_strobe,
    input  logic         irq_wake,
    input  logic         wdt_wake,
    output logic         cpu_clk_en,
    output logic         periph_clk_en,
    output logic [2:0]   src_select,
    output logic [2:0]   mode_code
);

    logic               wake;
    pm_mode_e           mode_d;
    pm_mode_e           mode_q;
    pm_clk_cfg_t        cfg;
    logic [NUM_SRC-1:0] want_oh;

    always_comb begin
        wake          = irq_wake | wdt_wake;
        cfg           = mode_cfg(mode_q);
        want_oh       = src_onehot(cfg.src);
        cpu_clk_en    = cfg.cpu_en;
        periph_clk_en = cfg.per_en;
        mode_code     = mode_q;
    end

    pm_next_mode u_next (
        .mode_q       (mode_q),
        .idle_sel     (idle_sel),
        .src_field    (clk_src_sel),
        .sleep_strobe (sleep_strobe),
        .wake         (wake),
        .mode_d       (mode_d)
    );

    pm_mode_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .mode_d (mode_d),
        .mode_q (mode_q)
    );

    pm_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .want_oh (want_oh),
        .sel_q   (src_select)
    );

    p_wake_to_pri_r7: assert property (@(posedge clk) disable iff (rst)
        wake |=> (mode_code == 3'd1));

    p_sleep_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd0 && !wake) |=> (mode_code == 3'd0));

    p_run_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (is_run(mode_q) && sleep_strobe && !wake) |=>
        (mode_q == PM_SLEEP) || (mode_q == idle_of(mode_src($past(mode_q)))));

    p_sleep_no_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd0) |=> (src_select == 3'b000) || (mode_code != 3'd0));

endmodule

// File: tb/pm_mode_ctrl_tb.sv
module pm_mode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_sel = 1'b0;
    logic [1:0] clk_src_sel = 2'b00;
    logic       sleep_strobe = 1'b0;
    logic       irq_wake = 1'b0;
    logic       wdt_wake = 1'b0;
    logic       cpu_clk_en, periph_clk_en;
    logic [2:0] src_select, mode_code;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pm_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .idle_sel(idle_sel), .clk_src_sel(clk_src_sel),
        .sleep_strobe(sleep_strobe), .irq_wake(irq_wake), .wdt_wake(wdt_wake),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .src_select(src_select), .mode_code(mode_code)
    );

    // vector: {idle, src[1:0], strobe, irq, wdt, expected mode[2:0]}
    localparam int NV = 26;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'd2},  // R4 R3 secondary
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 3'd3},  // R3 internal 10
        {1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd3},  // R3 internal 11
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd1},  // R4 primary
        {1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 3'd1},  // R4 idle bit blocks switch
        {1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 3'd4},  // R6 primary idle
        {1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 3'd4},  // R8 ignored in idle
        {1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 3'd1},  // R7 irq
        {1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'd2},  // R4
        {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 3'd5},  // R6 secondary idle
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 3'd1},  // R7 wdt
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 3'd3},  // R4
        {1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 3'd6},  // R6 internal idle
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3'd6},  // R8 field ignored
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'd1},  // R7
        {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 sleep
        {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 3'd0},  // R8 strobe in sleep
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 field in sleep
        {1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 3'd1},  // R7 wake from sleep
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 3'd3},  // R4
        {1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 3'd1},  // R7 wake beats strobe
        {1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'd2},  // R4
        {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 sleep from secondary
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'd1},  // R7
        {1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 3'd4},  // R6 uses current source, not field
        {1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'd1}   // R7
    };

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_en(input string req, input logic [2:0] m);
        chk(req, {2'b00, cpu_clk_en}, {2'b00, (m >= 3'd1 && m <= 3'd3)});   // R10
        chk(req, {2'b00, periph_clk_en}, {2'b00, (m != 3'd0)});             // R10
    endtask

    task automatic drive(input logic i, input logic [1:0] s, input logic st,
                         input logic q, input logic w);
        idle_sel = i; clk_src_sel = s; sleep_strobe = st; irq_wake = q; wdt_wake = w;
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 mode", mode_code, 3'd1);
        chk("R1 sel", src_select, 3'b001);
        chk_en("R1 enables", 3'd1);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][8], VEC[k][7:6], VEC[k][5], VEC[k][4], VEC[k][3]);
            step();
            chk($sformatf("vector %0d mode", k), mode_code, VEC[k][2:0]);
            chk_en($sformatf("vector %0d enables", k), VEC[k][2:0]);
        end
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        repeat (3) step();

        // R9 source switch primary -> secondary
        drive(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        step(); chk("R9 mode", mode_code, 3'd2); chk("R9 old sel held", src_select, 3'b001);
        step(); chk("R9 gap", src_select, 3'b000);
        step(); chk("R9 new sel", src_select, 3'b010);
        // R9 sleep drops select
        drive(1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        step(); chk("R5 sleep", mode_code, 3'd0); chk("R9 sel lag", src_select, 3'b010);
        drive(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        step(); chk("R9 sleep sel", src_select, 3'b000);
        step(); chk("R9 sleep sel held", src_select, 3'b000);
        // wake restores primary
        drive(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        step(); chk("R7 wake", mode_code, 3'd1); chk("R9 sel off", src_select, 3'b000);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        step(); chk("R9 primary sel", src_select, 3'b001);
        // same-source idle keeps select
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
        step(); chk("R6 idle", mode_code, 3'd4); chk("R9 idle sel", src_select, 3'b001);
        chk_en("R6 enables", 3'd4);
        drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        step(); chk("R8 idle hold", mode_code, 3'd4); chk("R9 idle sel held", src_select, 3'b001);
        // internal idle then reset
        drive(1'b0, 2'b11, 1'b0, 1'b1, 1'b0);
        step();
        drive(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        step(); step(); step();
        chk("R3 int sel", src_select, 3'b100);
        drive(1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
        step(); chk("R6 int idle", mode_code, 3'd6);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        step();
        chk("R1 reset mode", mode_code, 3'd1);
        chk("R1 reset sel", src_select, 3'b001);
        chk_en("R1 reset enables", 3'd1);
        rst = 1'b0;
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule